// File: doc/BRIEF.md
# Warp Issue Scheduler

This block selects which warp issues next in a pipeline that interleaves many warps. Each warp is one group of threads sharing a single program counter. The scheduler keeps one slot per warp. Each slot holds a state (idle, ready, in flight or waiting on memory) and the warp's PC. Each cycle it picks one ready warp and presents its ID and PC with a valid strobe. Successive issue slots go to different warps. No warp ever has more than one instruction in the pipeline, so downstream stages need no hazard interlock.

When an issued instruction retires, the pipeline reports it back, together with whether it was a memory access and whether any lane missed the data cache. A warp with no miss returns to the ready pool with its PC advanced. A warp with a miss is parked with its PC already advanced. A later fill-return naming that warp puts it back in the pool. Register contents are never saved or restored, because they stay resident while a warp is parked. Fetch, decode, the register file and the datapath sit outside this block.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every slot is idle with PC 0, and `issue_valid` is low until some warp has been made ready.
- R2: A high `warp_en` bit moves only an idle slot to ready. While the slot is in any other state the bit has no effect.
- R3: At most one warp issues per clock. The ID and PC of the chosen warp appear on the registered outputs one clock after it is seen ready. The chosen warp becomes in flight and is not issued again until its retire report.
- R4: The choice among ready warps is round-robin. The search starts one slot above the last issued warp and wraps from the top slot to slot 0. After reset the search starts at slot 0.
- R5: A retire report for an in-flight warp with `ret_mem` low, or with `ret_mem` high and `ret_miss` low, returns it to ready with PC+1.
- R6: A retire report for an in-flight warp with `ret_mem` and `ret_miss` both high parks it in the memory-wait state with PC+1. A parked warp is not issued.
- R7: A fill-return (`fill_valid` with `fill_wid`) moves that warp from memory-wait to ready without changing its PC. A fill-return for a warp in any other state has no effect.
- R8: A retire report naming a warp that is not in flight has no effect on its state or PC.
- R9: When no warp is ready, `issue_valid` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_en | input | NUM_WARPS | Per-warp flag that makes an idle warp ready |
| ret_valid | input | 1 | Retire report strobe |
| ret_wid | input | WID_W | Warp ID of the retiring instruction |
| ret_mem | input | 1 | Retiring instruction was a memory access |
| ret_miss | input | 1 | At least one lane missed the data cache |
| fill_valid | input | 1 | Fill-return strobe |
| fill_wid | input | WID_W | Warp whose missing data has returned |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_wid | output | WID_W | ID of the issuing warp |
| issue_pc | output | PC_W | PC of the issuing warp |

## Verification
Enabling all eight warps at once shows the in-order sweep from slot 0 and the idle cycle that follows. Adding two warps below and above the last issued one separates round-robin from fixed priority. A single warp retired through the plain path, the cache-hit path and the miss-plus-fill path separates the three PC and state transitions. Stray retire and fill reports aimed at idle, ready or parked warps show whether such reports corrupt state, which is seen as a spurious issue or a wrong PC at the next issue.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_READY = 2'd1,
    WS_INFL  = 2'd2,
    WS_MWAIT = 2'd3
  } wstate_e;
endpackage

// File: rtl/wsched_slot.sv
module wsched_slot
  import wsched_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            pick,
  input  logic            ret_hit,
  input  logic            ret_park,
  input  logic            fill_hit,
  output logic            is_ready,
  output logic [PC_W-1:0] pc
);
  wstate_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= WS_IDLE;
      pc <= '0;
    end else begin
      unique case (st)
        WS_IDLE:  if (en) st <= WS_READY;
        WS_READY: if (pick) st <= WS_INFL;
        WS_INFL:  if (ret_hit) begin
                    st <= ret_park ? WS_MWAIT : WS_READY;
                    pc <= pc + PC_W'(1);
                  end
        WS_MWAIT: if (fill_hit) st <= WS_READY;
        default:  st <= WS_IDLE;
      endcase
    end
  end

  assign is_ready = (st == WS_READY);

  // R3: a picked warp is in flight on the next cycle
  a_r3_pick_inflight: assert property (@(posedge clk) disable iff (rst)
    (pick && st == WS_READY) |=> st == WS_INFL);
  // R7: a parked warp stays parked until its fill arrives
  a_r7_park_hold: assert property (@(posedge clk) disable iff (rst)
    (st == WS_MWAIT && !fill_hit) |=> st == WS_MWAIT);
  // R8: PC moves only on a retire of an in-flight warp
  a_r8_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !(st == WS_INFL && ret_hit) |=> $stable(pc));
endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
  parameter int N     = 8,
  parameter int WID_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  input  logic [WID_W-1:0] last,
  output logic [N-1:0]     gnt,
  output logic             any,
  output logic [WID_W-1:0] wid
);
  always_comb begin
    gnt = '0;
    any = 1'b0;
    wid = '0;
    for (int i = 1; i <= N; i++) begin
      int cand;
      cand = (int'(last) + i) % N;
      if (!any && req[cand]) begin
        any       = 1'b1;
        wid       = WID_W'(cand);
        gnt[cand] = 1'b1;
      end
    end
  end

  // R4: a single grant, and only to a requester
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  a_r4_grant_req: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int PC_W      = 16,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warp_en,
  input  logic                 ret_valid,
  input  logic [WID_W-1:0]     ret_wid,
  input  logic                 ret_mem,
  input  logic                 ret_miss,
  input  logic                 fill_valid,
  input  logic [WID_W-1:0]     fill_wid,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_wid,
  output logic [PC_W-1:0]      issue_pc
);
  localparam logic [WID_W-1:0] TOP_SLOT = WID_W'(NUM_WARPS - 1);

  logic [NUM_WARPS-1:0] rdy, gnt;
  logic [PC_W-1:0]      pcs [NUM_WARPS];
  logic                 any;
  logic [WID_W-1:0]     sel, last_q;
  logic                 park;

  assign park = ret_mem & ret_miss;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    wsched_slot #(.PC_W(PC_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .en       (warp_en[w]),
      .pick     (gnt[w]),
      .ret_hit  (ret_valid && ret_wid == WID_W'(w)),
      .ret_park (park),
      .fill_hit (fill_valid && fill_wid == WID_W'(w)),
      .is_ready (rdy[w]),
      .pc       (pcs[w])
    );
  end

  wsched_rr_pick #(.N(NUM_WARPS), .WID_W(WID_W)) u_pick (
    .clk  (clk),
    .rst  (rst),
    .req  (rdy),
    .last (last_q),
    .gnt  (gnt),
    .any  (any),
    .wid  (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_wid   <= '0;
      issue_pc    <= '0;
      last_q      <= TOP_SLOT;
    end else begin
      issue_valid <= any;
      if (any) begin
        issue_wid <= sel;
        issue_pc  <= pcs[sel];
        last_q    <= sel;
      end
    end
  end

  // R3: one warp in flight at a time means no back-to-back issue of one warp
  a_r3_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid)) |-> issue_wid != $past(issue_wid));
  // R9: with nothing ready there is no issue on the next cycle
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    (rdy == '0) |=> !issue_valid);
endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int WW = 3;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] warp_en = '0;
  logic          ret_valid = 1'b0;
  logic [WW-1:0] ret_wid = '0;
  logic          ret_mem = 1'b0;
  logic          ret_miss = 1'b0;
  logic          fill_valid = 1'b0;
  logic [WW-1:0] fill_wid = '0;
  logic          issue_valid;
  logic [WW-1:0] issue_wid;
  logic [PW-1:0] issue_pc;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .PC_W(PW)) uut (
    .clk(clk), .rst(rst), .warp_en(warp_en),
    .ret_valid(ret_valid), .ret_wid(ret_wid), .ret_mem(ret_mem), .ret_miss(ret_miss),
    .fill_valid(fill_valid), .fill_wid(fill_wid),
    .issue_valid(issue_valid), .issue_wid(issue_wid), .issue_pc(issue_pc)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_issue(string req, int wid, int pc);
    check(req, int'(issue_valid), 1);
    check(req, int'(issue_wid), wid);
    check(req, int'(issue_pc), pc);
  endtask

  task automatic do_reset();
    rst = 1'b1; warp_en = '0; ret_valid = 0; fill_valid = 0; ret_mem = 0; ret_miss = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic retire(int wid, logic mem, logic miss);
    ret_valid = 1; ret_wid = WW'(wid); ret_mem = mem; ret_miss = miss;
    tick();
    ret_valid = 0; ret_mem = 0; ret_miss = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 idle after reset", int'(issue_valid), 0);
    tick(); tick();
    check("R1 no issue without enable", int'(issue_valid), 0);
  endtask

  task automatic t_single();
    do_reset();
    warp_en = 8'h08;
    tick();
    check("R3 output registered, not yet valid", int'(issue_valid), 0);
    tick();
    expect_issue("R3 first issue of warp 3", 3, 0);
    tick();
    check("R2 enable ignored while in flight", int'(issue_valid), 0);
    retire(5, 0, 0);
    check("R8 retire to idle warp", int'(issue_valid), 0);
    tick();
    check("R8 idle warp not issued", int'(issue_valid), 0);
    retire(3, 0, 0);
    check("R5 not yet reissued", int'(issue_valid), 0);
    tick();
    expect_issue("R5 reissue with PC+1", 3, 1);
  endtask

  task automatic t_rr_order();
    do_reset();
    warp_en = '1;
    tick();
    for (int k = 0; k < NW; k++) begin
      tick();
      expect_issue("R4 sweep from slot 0", k, 0);
    end
    tick();
    check("R9 nothing ready", int'(issue_valid), 0);
  endtask

  task automatic t_rr_skip();
    do_reset();
    warp_en = 8'h20;
    tick(); tick();
    expect_issue("R4 warp 5 issues", 5, 0);
    warp_en = 8'hA2;
    tick(); tick();
    expect_issue("R4 search above last goes first", 7, 0);
    tick();
    expect_issue("R4 wrap to lower slot", 1, 0);
  endtask

  task automatic t_miss();
    do_reset();
    warp_en = 8'h10;
    tick(); tick();
    expect_issue("R6 warp 4 issues", 4, 0);
    retire(4, 1, 1);
    fill_valid = 1; fill_wid = 3'd2;
    tick();
    fill_valid = 0;
    check("R7 stray fill to idle warp", int'(issue_valid), 0);
    retire(4, 0, 0);
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R6 parked warp not issued", int'(issue_valid), 0);
    end
    fill_valid = 1; fill_wid = 3'd4;
    tick();
    fill_valid = 0;
    check("R7 fill latency", int'(issue_valid), 0);
    tick();
    expect_issue("R7 R8 wake with PC advanced once", 4, 1);
  endtask

  task automatic t_hit();
    do_reset();
    warp_en = 8'h01;
    tick(); tick();
    expect_issue("R5 warp 0 issues", 0, 0);
    retire(0, 1, 0);
    tick();
    expect_issue("R5 cache hit returns to ready", 0, 1);
    tick();
    retire(0, 0, 0);
    fill_valid = 1; fill_wid = 3'd0;
    tick();
    fill_valid = 0;
    expect_issue("R7 fill to ready warp ignored", 0, 2);
    tick();
    check("R7 no extra issue", int'(issue_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_rr_order();
    t_rr_skip();
    t_miss();
    t_hit();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule